// File: doc/BRIEF.md
# Tagged Conversion Result FIFO

This block queues the records of finished high-priority analog-to-digital conversions until software collects them. Each time the converter finishes, it raises a one-cycle done strobe with the 10-bit result, the priority level of the trigger that started the conversion, and the channel number. The block stores these three fields together in one entry of a four-entry first-in first-out queue.

Software reads the oldest entry through a 32-bit read word and removes it with a pop strobe. A control bit places the result at the top or at the bottom of the low half-word. An empty flag tells software when a read is valid. A threshold flag rises once the occupancy reaches a programmed level. That flag drives an interrupt request through an enable bit. A sticky overrun flag records each record lost because the queue was full.

Top module: `prio_result_fifo`

## Requirements
- R1: After reset `fifo_empty` is 1 and `thr_flag`, `irq_req` and `ovr_flag` are 0.
- R2: An accepted write stores result, level and channel together as one entry. Entries come out of `rd_word` in the order in which they were written.
- R3: The first accepted write into an empty queue clears `fifo_empty` on the next cycle. Popping the last entry sets it again.
- R4: The queue holds exactly four entries. A write that arrives while it is full, with no pop in the same cycle, is dropped and leaves the stored entries unchanged.
- R5: A dropped write sets `ovr_flag`, which stays set until a cycle with `ovr_clr`=1. If a drop and a clear happen in the same cycle, the flag is set.
- R6: `thr_flag` is set by an accepted write after which the occupancy is at least `cfg_stages`+1, where `cfg_stages` is a 2-bit value from 0 to 3.
- R7: `thr_flag` stays set until a cycle with `flag_clr`=1. Pops never set it. After a clear, it is set again by the next accepted write if the occupancy is still at or above the threshold. If a qualifying write and a clear happen in the same cycle, the flag is set.
- R8: `irq_req` is 1 exactly when `thr_flag` and `irq_en` are both 1.
- R9: A pop while the queue is empty is ignored and does not advance the read position. The next written entry is the one presented on `rd_word`.
- R10: A write and a pop in the same cycle leave the occupancy unchanged. This also holds when the queue is full: the write is then accepted and no overrun is flagged.
- R11: `rd_word` layout: the channel is at bits [28:24] and the level at bits [18:16]. With `cfg_left`=1 the result is at [15:6] and bits [5:0] are 0. With `cfg_left`=0 the result is at [9:0] and bits [15:10] are 0. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cv_done | input | 1 | One-cycle conversion-finished strobe |
| cv_result | input | 10 | Conversion result |
| cv_level | input | 3 | Priority level of the start trigger |
| cv_chan | input | 5 | Converted channel number |
| rd_pop | input | 1 | Remove the oldest entry |
| rd_word | output | 32 | Formatted oldest entry |
| cfg_stages | input | 2 | Threshold field N; the flag rises at N+1 entries |
| cfg_left | input | 1 | 1 = left-justified result, 0 = right-justified |
| irq_en | input | 1 | Interrupt request enable |
| flag_clr | input | 1 | Clear the threshold flag |
| ovr_clr | input | 1 | Clear the overrun flag |
| fifo_empty | output | 1 | Queue holds no entry |
| thr_flag | output | 1 | Occupancy threshold flag |
| irq_req | output | 1 | Gated interrupt request |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bench targets several corner cases:
- A pop on an empty queue: a design that advanced its read position there would later present a stale slot instead of the next record.
- A write and pop together on a full queue: a wrong design would either drop the write and raise a false overrun, or lose an entry.
- A clear of either flag in the same cycle as its set condition: a wrong design would let the clear win and miss the event.
- The threshold flag after a clear: a wrong design would fail to re-arm on the next write, or re-arm on a pop.

Random traffic with changing threshold and alignment settings checks the order, the packing and both justifications against a queue model in the bench.

// File: rtl/prio_fifo_pkg.sv
package prio_fifo_pkg;
   localparam int RES_W  = 10;
   localparam int LVL_W  = 3;
   localparam int CH_W   = 5;
   localparam int WORD_W = 32;

   typedef struct packed {
      logic [RES_W-1:0] res;
      logic [LVL_W-1:0] lvl;
      logic [CH_W-1:0]  ch;
   } conv_rec_t;

   localparam int REC_W = $bits(conv_rec_t);
endpackage

// File: rtl/prio_fifo_store.sv
module prio_fifo_store
   import prio_fifo_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  conv_rec_t        wr_rec,
   output conv_rec_t        head_rec,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] count_nxt,
   output logic             empty,
   output logic             full,
   output logic             push_ok,
   output logic             pop_ok
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("prio_fifo_store: DEPTH must be at least 2");
   end

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   conv_rec_t        mem [DEPTH];

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);

   always_comb begin
      count_nxt = count;
      if (push_ok && !pop_ok) count_nxt = count + 1'b1;
      else if (pop_ok && !push_ok) count_nxt = count - 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) mem[i] <= '0;
         else if (push_ok && wr_ptr == PTR_W'(i)) mem[i] <= wr_rec;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
         if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
         count <= count_nxt;
      end
   end

   assign head_rec = mem[rd_ptr];

   assert_empty_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && empty) |=> !empty);
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   assert_empty_pop_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty) |=> $stable(rd_ptr));
   assert_push_pop_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !empty) |=> $stable(count));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int CNT_W = 3,
   parameter int STG_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [STG_W-1:0] stages,
   input  logic             push_ok,
   input  logic             drop,
   input  logic [CNT_W-1:0] count_nxt,
   input  logic             flag_clr,
   input  logic             ovr_clr,
   input  logic             irq_en,
   output logic             thr_flag,
   output logic             irq_req,
   output logic             ovr_flag
);
   localparam int CMP_W = (CNT_W > STG_W) ? CNT_W + 1 : STG_W + 1;

   logic [CMP_W-1:0] thresh;
   logic             thr_hit;

   assign thresh  = CMP_W'(stages) + 1'b1;
   assign thr_hit = push_ok && (CMP_W'(count_nxt) >= thresh);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_flag <= 1'b0;
         ovr_flag <= 1'b0;
      end else begin
         if (thr_hit)       thr_flag <= 1'b1;
         else if (flag_clr) thr_flag <= 1'b0;
         if (drop)          ovr_flag <= 1'b1;
         else if (ovr_clr)  ovr_flag <= 1'b0;
      end
   end

   assign irq_req = thr_flag & irq_en;

   assert_flag_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thr_flag) |-> $past(push_ok));
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_flag && !flag_clr) |=> thr_flag);
   assert_ovr_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> $past(drop));
endmodule

// File: rtl/prio_rd_format.sv
module prio_rd_format
   import prio_fifo_pkg::*;
#(
   parameter int CH_LSB  = 24,
   parameter int LVL_LSB = 16,
   parameter int HALF_W  = 16
) (
   input  conv_rec_t          rec,
   input  logic               left,
   output logic [WORD_W-1:0]  word
);
   localparam int LEFT_LSB = HALF_W - RES_W;

   if (LEFT_LSB < 0 || CH_LSB + CH_W > WORD_W || LVL_LSB + LVL_W > CH_LSB
       || LVL_LSB < HALF_W) begin : g_bad_layout
      $error("prio_rd_format: field layout does not fit the read word");
   end

   logic [HALF_W-1:0] low_half;

   always_comb begin
      low_half = left ? (HALF_W'(rec.res) << LEFT_LSB) : HALF_W'(rec.res);
      word = '0;
      word[HALF_W-1:0]            = low_half;
      word[LVL_LSB +: LVL_W]      = rec.lvl;
      word[CH_LSB +: CH_W]        = rec.ch;
   end
endmodule

// File: rtl/prio_result_fifo.sv
module prio_result_fifo
   import prio_fifo_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int STG_W = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cv_done,
   input  logic [RES_W-1:0]  cv_result,
   input  logic [LVL_W-1:0]  cv_level,
   input  logic [CH_W-1:0]   cv_chan,
   input  logic              rd_pop,
   output logic [WORD_W-1:0] rd_word,
   input  logic [STG_W-1:0]  cfg_stages,
   input  logic              cfg_left,
   input  logic              irq_en,
   input  logic              flag_clr,
   input  logic              ovr_clr,
   output logic              fifo_empty,
   output logic              thr_flag,
   output logic              irq_req,
   output logic              ovr_flag
);
   if ((1 << STG_W) > DEPTH) begin : g_bad_stage
      $error("prio_result_fifo: threshold field exceeds queue depth");
   end

   conv_rec_t        wr_rec, head_rec;
   logic [CNT_W-1:0] count, count_nxt;
   logic             full, push_ok, pop_ok;

   assign wr_rec = '{res: cv_result, lvl: cv_level, ch: cv_chan};

   prio_fifo_store #(.DEPTH(DEPTH)) i_store (
      .clk(clk), .rst_n(rst_n), .push(cv_done), .pop(rd_pop),
      .wr_rec(wr_rec), .head_rec(head_rec), .count(count),
      .count_nxt(count_nxt), .empty(fifo_empty), .full(full),
      .push_ok(push_ok), .pop_ok(pop_ok)
   );

   prio_irq_ctrl #(.CNT_W(CNT_W), .STG_W(STG_W)) i_irq (
      .clk(clk), .rst_n(rst_n), .stages(cfg_stages), .push_ok(push_ok),
      .drop(cv_done && !push_ok), .count_nxt(count_nxt),
      .flag_clr(flag_clr), .ovr_clr(ovr_clr), .irq_en(irq_en),
      .thr_flag(thr_flag), .irq_req(irq_req), .ovr_flag(ovr_flag)
   );

   prio_rd_format i_fmt (
      .rec(head_rec), .left(cfg_left), .word(rd_word)
   );

   assert_full_pop_no_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (full && rd_pop && cv_done) |-> push_ok);
   assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && cv_done && !rd_pop) |=> ovr_flag);
endmodule

// File: tb/test_prio_result_fifo.sv
module test_prio_result_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cv_done = 0, rd_pop = 0, cfg_left = 0, irq_en = 0;
   logic        flag_clr = 0, ovr_clr = 0;
   logic [9:0]  cv_result = '0;
   logic [2:0]  cv_level = '0;
   logic [4:0]  cv_chan = '0;
   logic [1:0]  cfg_stages = '0;
   logic [31:0] rd_word;
   logic        fifo_empty, thr_flag, irq_req, ovr_flag;

   int total = 0, bad = 0;
   bit done = 0;
   logic [17:0] q[$];
   bit m_flag = 0, m_ovr = 0;

   always #4 clk = ~clk;

   prio_result_fifo i_prio_result_fifo (.*);

   function automatic logic [31:0] fmt_word(logic [17:0] e, bit left);
      logic [31:0] w = '0;
      w[28:24] = e[4:0];
      w[18:16] = e[7:5];
      if (left) w[15:6] = e[17:8];
      else      w[9:0]  = e[17:8];
      return w;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_outs();
      chk("R3 empty", 32'(fifo_empty), 32'(q.size() == 0));
      chk("R7 thr_flag", 32'(thr_flag), 32'(m_flag));
      chk("R8 irq_req", 32'(irq_req), 32'(m_flag && irq_en));
      chk("R5 ovr_flag", 32'(ovr_flag), 32'(m_ovr));
      if (q.size() != 0) chk("R2/R11 rd_word", rd_word, fmt_word(q[0], cfg_left));
   endtask

   task automatic step(bit wr, logic [9:0] r, logic [2:0] l, logic [4:0] c,
                       bit pop, bit fc, bit oc);
      bit pop_ok, push_ok;
      cv_done = wr; cv_result = r; cv_level = l; cv_chan = c;
      rd_pop = pop; flag_clr = fc; ovr_clr = oc;
      #1;
      check_outs();
      pop_ok  = pop && q.size() != 0;
      push_ok = wr && (q.size() < 4 || pop_ok);
      if (pop_ok) void'(q.pop_front());
      if (push_ok) q.push_back({r, l, c});
      if (push_ok && q.size() >= int'(cfg_stages) + 1) m_flag = 1;
      else if (fc) m_flag = 0;
      if (wr && !push_ok) m_ovr = 1;
      else if (oc) m_ovr = 0;
      @(negedge clk);
      cv_done = 0; rd_pop = 0; flag_clr = 0; ovr_clr = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 empty", 32'(fifo_empty), 32'd1);
      chk("R1 thr_flag", 32'(thr_flag), 32'd0);
      chk("R1 irq_req", 32'(irq_req), 32'd0);
      chk("R1 ovr_flag", 32'(ovr_flag), 32'd0);
      @(negedge clk);
      // R9: pops on empty are ignored
      cfg_stages = 2'd3; irq_en = 1;
      step(0, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 1, 0, 0);
      step(1, 10'h2a5, 3'd5, 5'd17, 0, 0, 0);
      cfg_left = 1; #1;
      chk("R9 head after empty pops", rd_word, fmt_word({10'h2a5, 3'd5, 5'd17}, 1));
      cfg_left = 0; #1;
      chk("R11 right justified", rd_word, {3'b0, 5'd17, 5'b0, 3'd5, 6'b0, 10'h2a5});
      // R4/R6: fill to four then overflow
      step(1, 10'h001, 3'd1, 5'd1, 0, 0, 0);
      step(1, 10'h002, 3'd2, 5'd2, 0, 0, 0);
      step(1, 10'h003, 3'd3, 5'd3, 0, 0, 0);
      chk("R6 flag at four", 32'(thr_flag), 32'd1);
      // R5: drop with clear in same cycle keeps overrun set
      step(1, 10'h3ff, 3'd7, 5'd31, 0, 0, 1);
      chk("R5 overrun set", 32'(ovr_flag), 32'd1);
      // R10: full push+pop accepted
      step(1, 10'h155, 3'd6, 5'd9, 1, 0, 1);
      chk("R10 no overrun", 32'(ovr_flag), 32'd0);
      // R7: clear with no write, then pop must not set
      step(0, 0, 0, 0, 0, 1, 0);
      chk("R7 cleared", 32'(thr_flag), 32'd0);
      step(0, 0, 0, 0, 1, 0, 0);
      chk("R7 pop no set", 32'(thr_flag), 32'd0);
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, 0);
      check_outs();
      // random traffic
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 15) == 0) cfg_stages = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 7) == 0) cfg_left = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 7) == 0) irq_en = 1'($urandom_range(0, 1));
         step($urandom_range(0, 9) < 5, 10'($urandom), 3'($urandom), 5'($urandom),
              $urandom_range(0, 9) < 4, $urandom_range(0, 9) == 0,
              $urandom_range(0, 9) == 0);
      end
      check_outs();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule